// File: doc/BRIEF.md
# Platform Miscellaneous Control Register Block

This block is a small register file placed next to a processor core. It reports which ports of the on-chip bus crossbar have a slave or a master attached, and it holds the bit that picks the crossbar's arbitration policy. It also collects six floating-point exception flags into one maskable interrupt line. A third function runs a compute-operation request and acknowledge handshake with the low-power controller, and an interrupt vector fetch can withdraw that request.

Software reaches the registers over a simple single-cycle bus. A request is either a write or a read. A read returns its data, with a valid strobe, one clock after the request edge. The floating-point flags arrive already sticky from the core and are shown here only as mirrors. The acknowledge comes straight from the low-power controller.

Top module: `plat_misc_ctrl`

## Requirements
- R1: After reset, reads return 0x0000001F at offset 0x08, 0x00000017 at 0x0A, 0 at 0x0C, 0x00020000 at 0x10 and 0 at 0x40.
- R2: Offsets 0x08 (slave presence) and 0x0A (master presence) are read-only. Writes to them have no effect, and bits 31:8 of each read as zero.
- R3: Bit 9 of offset 0x0C is read/write and drives `arb_rr` (0 = fixed priority, 1 = round robin). All other bits of that register read zero whatever was written.
- R4: At offset 0x10, bits 8, 9, 10, 11, 12 and 15 read the live values of `fpu_flags[0]` to `fpu_flags[5]` (invalid op, divide by zero, overflow, underflow, inexact, input denormal). Writes never change them.
- R5: At offset 0x10, bits 24, 25, 26, 27, 28 and 31 are read/write enables that pair with status bits 8, 9, 10, 11, 12 and 15. Bit 17 always reads 1, and every other bit reads 0.
- R6: `fpu_irq` is a registered output. It is 1 in the cycle after an edge where some flag and its enable were both 1, and 0 otherwise.
- R7: At offset 0x40, bit 0 (request) and bit 2 (wake on interrupt) are read/write, and `cmpop_req` follows bit 0.
- R8: A `vec_fetch` pulse clears the request bit when wake on interrupt is 1 and leaves it unchanged when wake on interrupt is 0.
- R9: If a write that sets the request falls in the same cycle as a clearing vector fetch, the request ends up 0.
- R10: Bit 1 at offset 0x40 reads the `lp_entry_done` input, and writes to it have no effect.
- R11: A read asserts `bus_rvalid` for one cycle after the request edge, with data sampled at that edge. Offsets that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one clock after a read request |
| fpu_flags | input | 6 | Sticky exception flags from the FPU |
| vec_fetch | input | 1 | Interrupt or exception vector fetch strobe |
| lp_entry_done | input | 1 | 1 from completed entry until completed exit |
| fpu_irq | output | 1 | Masked exception interrupt request |
| arb_rr | output | 1 | Crossbar arbitration mode |
| cmpop_req | output | 1 | Compute-operation request |

## Verification
The bench writes all ones to every register. Any writable status bit, presence bit or reserved bit then shows up on readback, and so does a missing constant bit 17. It raises the one enabled flag and samples `fpu_irq` both before and after the clock edge. An interrupt that is unregistered fires too early, and a mask that is wired wrong fires on disabled flags. It pulses the vector fetch with wake on interrupt both clear and set, and once in the same cycle as a write that sets the request. A design that ignores the control bit, or that lets the write win, leaves `cmpop_req` at the wrong value.

// File: rtl/plat_misc_pkg.sv
package plat_misc_pkg;
  localparam int BUS_AW     = 8;
  localparam int BUS_DW     = 32;
  localparam int FPU_NFLAGS = 6;
  localparam int PRES_W     = 16;

  localparam logic [BUS_AW-1:0] OFS_SLV = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_MST = 8'h0A;
  localparam logic [BUS_AW-1:0] OFS_ARB = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_FPU = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_CMP = 8'h40;

  localparam int ARB_BIT       = 9;
  localparam int ISCR_ONE_BIT  = 17;
  localparam int CMP_REQ_BIT   = 0;
  localparam int CMP_ACK_BIT   = 1;
  localparam int CMP_WOI_BIT   = 2;
  localparam int EN_SHIFT      = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SLV, SEL_MST, SEL_ARB, SEL_FPU, SEL_CMP
  } reg_sel_e;

  // status bit of flag i: five contiguous from 8, the last one at 15
  function automatic int sts_pos(input int i);
    return (i == FPU_NFLAGS - 1) ? 15 : 8 + i;
  endfunction

  function automatic int en_pos(input int i);
    return sts_pos(i) + EN_SHIFT;
  endfunction

  function automatic reg_sel_e decode_sel(input logic [BUS_AW-1:0] a);
    case (a)
      OFS_SLV: return SEL_SLV;
      OFS_MST: return SEL_MST;
      OFS_ARB: return SEL_ARB;
      OFS_FPU: return SEL_FPU;
      OFS_CMP: return SEL_CMP;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/plat_xbar_cfg.sv
module plat_xbar_cfg
  import plat_misc_pkg::*;
#(
  parameter int                  XBAR_PORTS = 8,
  parameter logic [XBAR_PORTS-1:0] SLV_MAP  = 8'h1F,
  parameter logic [XBAR_PORTS-1:0] MST_MAP  = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_arb,
  input  logic              arb_wbit,
  output logic [BUS_DW-1:0] slv_word,
  output logic [BUS_DW-1:0] mst_word,
  output logic [BUS_DW-1:0] arb_word,
  output logic              arb_rr
);
  localparam int PAD_W = BUS_DW - XBAR_PORTS;

  logic arb_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      arb_q <= 1'b0;
    else if (wr_arb) arb_q <= arb_wbit;
  end

  assign slv_word = {{PAD_W{1'b0}}, SLV_MAP};
  assign mst_word = {{PAD_W{1'b0}}, MST_MAP};

  always_comb begin
    arb_word          = '0;
    arb_word[ARB_BIT] = arb_q;
  end

  assign arb_rr = arb_q;

  AST_ARB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_arb |=> $stable(arb_rr)); // R3
endmodule

// File: rtl/plat_fpu_irq.sv
module plat_fpu_irq
  import plat_misc_pkg::*;
#(
  parameter int NF = FPU_NFLAGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_iscr,
  input  logic [NF-1:0]     en_wbits,
  input  logic [NF-1:0]     flags,
  output logic [BUS_DW-1:0] iscr_word,
  output logic              irq
);
  logic [NF-1:0] en_q;
  logic [NF-1:0] hit;
  logic          irq_d;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_iscr) en_q <= en_wbits;
  end

  assign hit   = flags & en_q;
  assign irq_d = |hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    iscr_word               = '0;
    iscr_word[ISCR_ONE_BIT] = 1'b1;
    for (int i = 0; i < NF; i++) begin
      iscr_word[sts_pos(i)] = flags[i];
      iscr_word[en_pos(i)]  = en_q[i];
    end
  end

  assign irq = irq_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|en_q)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|flags)); // R6
endmodule

// File: rtl/plat_cmpop.sv
module plat_cmpop
  import plat_misc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cpo,
  input  logic              req_wbit,
  input  logic              woi_wbit,
  input  logic              vec_fetch,
  input  logic              lp_done,
  output logic [BUS_DW-1:0] cpo_word,
  output logic              req
);
  logic req_q;
  logic woi_q;
  logic fetch_clear;

  assign fetch_clear = vec_fetch & woi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      woi_q <= 1'b0;
    end else begin
      if (wr_cpo) woi_q <= woi_wbit;
      if (fetch_clear)  req_q <= 1'b0;
      else if (wr_cpo)  req_q <= req_wbit;
    end
  end

  always_comb begin
    cpo_word              = '0;
    cpo_word[CMP_REQ_BIT] = req_q;
    cpo_word[CMP_ACK_BIT] = lp_done;
    cpo_word[CMP_WOI_BIT] = woi_q;
  end

  assign req = req_q;

  AST_FETCH_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && woi_q) |=> !req); // R8
  AST_REQ_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cpo && !vec_fetch) |=> $stable(req)); // R7
endmodule

// File: rtl/plat_misc_ctrl.sv
module plat_misc_ctrl
  import plat_misc_pkg::*;
#(
  parameter int                    XBAR_PORTS = 8,
  parameter logic [XBAR_PORTS-1:0] SLV_MAP    = 8'h1F,
  parameter logic [XBAR_PORTS-1:0] MST_MAP    = 8'h17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [BUS_AW-1:0]     bus_addr,
  input  logic [BUS_DW-1:0]     bus_wdata,
  output logic [BUS_DW-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  input  logic [FPU_NFLAGS-1:0] fpu_flags,
  input  logic                  vec_fetch,
  input  logic                  lp_entry_done,
  output logic                  fpu_irq,
  output logic                  arb_rr,
  output logic                  cmpop_req
);
  reg_sel_e              sel;
  logic                  wr_fire, rd_fire;
  logic                  wr_arb, wr_iscr, wr_cpo;
  logic [FPU_NFLAGS-1:0] en_wbits;
  logic [BUS_DW-1:0]     slv_word, mst_word, arb_word, iscr_word, cpo_word;
  logic [BUS_DW-1:0]     rd_mux;
  logic [BUS_DW-1:0]     rdata_q;
  logic                  rvalid_q;
  logic                  unused_wdata;

  assign sel     = decode_sel(bus_addr);
  assign wr_fire = bus_en & bus_we;
  assign rd_fire = bus_en & ~bus_we;
  assign wr_arb  = wr_fire && (sel == SEL_ARB);
  assign wr_iscr = wr_fire && (sel == SEL_FPU);
  assign wr_cpo  = wr_fire && (sel == SEL_CMP);

  always_comb begin
    for (int i = 0; i < FPU_NFLAGS; i++) en_wbits[i] = bus_wdata[en_pos(i)];
  end

  assign unused_wdata = ^bus_wdata;

  plat_xbar_cfg #(
    .XBAR_PORTS(XBAR_PORTS), .SLV_MAP(SLV_MAP), .MST_MAP(MST_MAP)
  ) u_xbar (
    .clk(clk), .rst_n(rst_n), .wr_arb(wr_arb), .arb_wbit(bus_wdata[ARB_BIT]),
    .slv_word(slv_word), .mst_word(mst_word), .arb_word(arb_word), .arb_rr(arb_rr)
  );

  plat_fpu_irq #(.NF(FPU_NFLAGS)) u_fpu (
    .clk(clk), .rst_n(rst_n), .wr_iscr(wr_iscr), .en_wbits(en_wbits),
    .flags(fpu_flags), .iscr_word(iscr_word), .irq(fpu_irq)
  );

  plat_cmpop u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_cpo(wr_cpo),
    .req_wbit(bus_wdata[CMP_REQ_BIT]), .woi_wbit(bus_wdata[CMP_WOI_BIT]),
    .vec_fetch(vec_fetch), .lp_done(lp_entry_done),
    .cpo_word(cpo_word), .req(cmpop_req)
  );

  always_comb begin
    case (sel)
      SEL_SLV: rd_mux = slv_word;
      SEL_MST: rd_mux = mst_word;
      SEL_ARB: rd_mux = arb_word;
      SEL_FPU: rd_mux = iscr_word;
      SEL_CMP: rd_mux = cpo_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_en && !bus_we)); // R11
  AST_READ_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !vec_fetch) |=> $stable(cmpop_req)); // R7
endmodule

// File: tb/plat_misc_ctrl_bench.sv
module plat_misc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [5:0]  fpu_flags = '0;
  logic        vec_fetch = 1'b0;
  logic        lp_entry_done = 1'b0;
  logic        fpu_irq, arb_rr, cmpop_req;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] addr; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  plat_misc_ctrl u_plat_misc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .fpu_flags(fpu_flags), .vec_fetch(vec_fetch),
    .lp_entry_done(lp_entry_done), .fpu_irq(fpu_irq), .arb_rr(arb_rr),
    .cmpop_req(cmpop_req)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected FP status/control word from the requirement text (R4, R5)
  function automatic logic [31:0] iscr_exp(input logic [5:0] fl, input logic [5:0] en);
    logic [31:0] w;
    w = 32'h0002_0000;
    w[8] = fl[0]; w[9] = fl[1]; w[10] = fl[2]; w[11] = fl[3]; w[12] = fl[4]; w[15] = fl[5];
    w[24] = en[0]; w[25] = en[1]; w[26] = en[2]; w[27] = en[3]; w[28] = en[4]; w[31] = en[5];
    return w;
  endfunction

  // monitor: pops expected items as read data comes back
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb.size() == 0) check(1, 0, "R11 unexpected rvalid");
      else begin
        item_t it;
        it = sb.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.addr = a; it.exp = exp; it.tag = tag;
    @(negedge clk);
    sb.push_back(it);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input bit fetch);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; vec_fetch = fetch;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; vec_fetch = 1'b0;
  endtask

  task automatic pulse_fetch();
    @(negedge clk);
    vec_fetch = 1'b1;
    @(negedge clk);
    vec_fetch = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R11 unmapped offset
    check({29'd0, fpu_irq, arb_rr, cmpop_req}, 0, "R1 outputs after reset");
    do_read(8'h08, 32'h1F, "R1 slave presence");
    do_read(8'h0A, 32'h17, "R1 master presence");
    do_read(8'h0C, 32'h0, "R1 arbitration reg");
    do_read(8'h10, 32'h0002_0000, "R1 fp status/control");
    do_read(8'h40, 32'h0, "R1 compute-op reg");
    do_read(8'h14, 32'h0, "R11 unmapped offset");
    // R2 read-only presence
    do_write(8'h08, 32'hFFFF_FFFF, 0);
    do_write(8'h0A, 32'hFFFF_FFFF, 0);
    do_read(8'h08, 32'h1F, "R2 slave presence after write");
    do_read(8'h0A, 32'h17, "R2 master presence after write");
    // R3 arbitration bit
    do_write(8'h0C, 32'hFFFF_FFFF, 0);
    check(arb_rr, 1, "R3 arb_rr set");
    do_read(8'h0C, 32'h0000_0200, "R3 only bit 9 kept");
    do_write(8'h0C, 32'h0, 0);
    check(arb_rr, 0, "R3 arb_rr cleared");
    // R6 masked flags
    @(negedge clk); fpu_flags = 6'b011111;
    @(negedge clk); @(negedge clk);
    check(fpu_irq, 0, "R6 no enable no irq");
    do_write(8'h10, 32'h8000_0000, 0);
    @(negedge clk);
    check(fpu_irq, 0, "R6 disabled flags masked");
    fpu_flags[5] = 1'b1;
    #1 check(fpu_irq, 0, "R6 irq not before clock");
    @(negedge clk);
    check(fpu_irq, 1, "R6 irq one clock after enabled flag");
    fpu_flags[5] = 1'b0;
    @(negedge clk);
    check(fpu_irq, 0, "R6 irq drops with source");
    // R4 mirrored status, R5 enables
    do_read(8'h10, iscr_exp(6'b011111, 6'b100000), "R4 status mirror");
    do_write(8'h10, 32'hFFFF_FFFF, 0);
    do_read(8'h10, iscr_exp(6'b011111, 6'b111111), "R5 enables set, R4 status unwritable");
    @(negedge clk);
    check(fpu_irq, 1, "R6 irq from inexact etc");
    fpu_flags = 6'b000000;
    do_read(8'h10, iscr_exp(6'b000000, 6'b111111), "R4 status follows cleared source");
    do_write(8'h10, 32'h0000_0000, 0);
    @(negedge clk);
    check(fpu_irq, 0, "R6 irq off after enables cleared");
    // R10 acknowledge
    lp_entry_done = 1'b1;
    do_read(8'h40, 32'h2, "R10 ack follows input");
    lp_entry_done = 1'b0;
    do_write(8'h40, 32'h2, 0);
    do_read(8'h40, 32'h0, "R10 ack not writable");
    // R7 request
    do_write(8'h40, 32'h1, 0);
    check(cmpop_req, 1, "R7 request set");
    do_read(8'h40, 32'h1, "R7 request readback");
    // R8 fetch without wake: no effect
    pulse_fetch();
    check(cmpop_req, 1, "R8 fetch ignored when woi=0");
    // R8 fetch with wake: clears
    do_write(8'h40, 32'h5, 0);
    check(cmpop_req, 1, "R7 request with woi");
    pulse_fetch();
    check(cmpop_req, 0, "R8 fetch clears request");
    do_read(8'h40, 32'h4, "R8 woi kept, req cleared");
    // R9 clear wins over simultaneous set
    do_write(8'h40, 32'h5, 1);
    check(cmpop_req, 0, "R9 clear beats write");
    do_read(8'h40, 32'h4, "R9 readback");
    repeat (3) @(negedge clk);
    check(sb.size(), 0, "R11 every read answered");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule